// File: doc/BRIEF.md
# Package Frequency and Idle Arbiter

This block sits in the power-management logic of a small multi-core package. Every cycle it takes an idle-state code and a requested frequency ratio from each core, plus idle flags from the PCIe and remote-socket traffic sources. From these it makes two decisions. The first is the package operating ratio, an integer multiple of a fixed 100 MHz base clock. The ratio moves only in whole base-clock steps. The second is the package idle level.

A core votes on the package ratio only while it is running or in light C1 sleep. Deeper sleepers give up their vote. The granted ratio is the highest clamped request among the cores that still vote. It falls to a configured floor when nobody votes. It is capped at a configured efficient ratio once every core has left C0. The package idle level is the deepest level that both the cores and the non-core traffic sources allow. A separate output asks for the uncore to stay powered whenever the deepest level cannot be entered.

All outputs are registered and follow the inputs with one cycle of latency.

Top module: `pkg_freq_idle_arb`

## Requirements
- R1: The granted ratio is the largest clamped request among the voting cores. A voting core is one whose decoded state is C0 or C1.
- R2: Each request below MIN_RATIO is raised to MIN_RATIO, and each request above MAX_RATIO is lowered to MAX_RATIO, before any comparison.
- R3: A core in C1e (code 2), C3 (code 3) or C6 (code 6) has no effect on the granted ratio.
- R4: When no core votes, the granted ratio is MIN_RATIO.
- R5: When every core is out of C0 and at least one core votes, the granted ratio is the smaller of the voting maximum and EFF_RATIO.
- R6: The state codes are C0=0, C1=1, C1e=2, C3=3 and C6=6. Codes 4, 5 and 7 are treated as C0, which means the core votes and the package counts it as active.
- R7: pkgState is 0 (active) while any core is in C0. It is 1 (light package idle) when all cores are in C1 or deeper but not all of them are in C3 or C6.
- R8: When all cores are in C3 or C6 and both pcieIdle and remoteIdle are high, pkgState is 3 (deep) and uncoreActive is 0.
- R9: When all cores are in C3 or C6 but pcieIdle or remoteIdle is low, pkgState is 2 (held) and uncoreActive is 1. uncoreActive is 1 in every state other than 3.
- R10: A synchronous active-high reset sets the granted ratio to MIN_RATIO, pkgState to 0 and uncoreActive to 1.
- R11: Every output reflects the inputs sampled at the previous rising clock edge. It does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coreCState | input | NUM_CORES*3 | Per-core idle-state code; core i uses bits [3i+2:3i] |
| coreRatioReq | input | NUM_CORES*RATIO_W | Per-core requested ratio; core i uses bits [RATIO_W*i +: RATIO_W] |
| pcieIdle | input | 1 | High when PCIe traffic is idle |
| remoteIdle | input | 1 | High when the remote socket is idle |
| grantRatio | output | RATIO_W | Granted package ratio in base-clock steps |
| pkgState | output | 2 | Package idle level: 0 active, 1 light, 2 held, 3 deep |
| uncoreActive | output | 1 | Request to keep the uncore powered |

## Verification
Several directed patterns are applied, and each one isolates a single rule:
- All cores running with out-of-range requests shows that clamping happens at both ends.
- One runner among deep sleepers, each sleeper requesting a huge ratio, shows that sleepers lose their vote.
- A mix of C1 and deep cores shows the efficient cap applying while the package sits at light idle.
- Only C1e, C3 and C6 cores shows the fall to the floor ratio.
- All-deep patterns with each traffic source toggled in turn tell the held level apart from the deep level, and show the uncore request with them.
- Codes 4, 5 and 7 check that unknown codes behave exactly as C0.

Seeded random mixes of all eight codes and requests in the range 0 to 63 then cover combinations of these rules, including the points where one rule takes over from another.

// File: rtl/pkg_arb_pkg.sv
package pkg_arb_pkg;

  localparam int CS_W = 3;

  typedef enum logic [2:0] {
    CS_C0  = 3'd0,
    CS_C1  = 3'd1,
    CS_C1E = 3'd2,
    CS_C3  = 3'd3,
    CS_C6  = 3'd6
  } coreState_e;

  typedef enum logic [1:0] {
    PKG_ACTIVE = 2'd0,
    PKG_LIGHT  = 2'd1,
    PKG_HOLD   = 2'd2,
    PKG_DEEP   = 2'd3
  } pkgIdle_e;

  // Strobes from control to the ratio datapath
  typedef struct packed {
    logic forceMin;  // no core holds a vote
    logic capEff;    // every core is out of C0
  } arbStrobes_t;

  // Unknown codes fold to C0
  function automatic coreState_e decodeState(input logic [CS_W-1:0] code);
    case (code)
      3'd1:    return CS_C1;
      3'd2:    return CS_C1E;
      3'd3:    return CS_C3;
      3'd6:    return CS_C6;
      default: return CS_C0;
    endcase
  endfunction

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import pkg_arb_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CORES*CS_W-1:0] coreCState,
  input  logic                      pcieIdle,
  input  logic                      remoteIdle,
  output logic [NUM_CORES-1:0]      voteMask,
  output arbStrobes_t               strobes,
  output logic [1:0]                pkgState,
  output logic                      uncoreActive
);

  logic [NUM_CORES-1:0] asleepMask;
  logic [NUM_CORES-1:0] deepMask;
  logic                 allAsleep;
  logic                 allDeep;
  logic                 ioQuiet;
  pkgIdle_e             nextState;
  pkgIdle_e             stateQ;
  logic                 uncoreQ;

  generate
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
      coreState_e st;
      assign st            = decodeState(coreCState[g*CS_W +: CS_W]);
      assign voteMask[g]   = (st == CS_C0) || (st == CS_C1);
      assign asleepMask[g] = (st != CS_C0);
      assign deepMask[g]   = (st == CS_C3) || (st == CS_C6);
    end
  endgenerate

  assign allAsleep = &asleepMask;
  assign allDeep   = &deepMask;
  assign ioQuiet   = pcieIdle && remoteIdle;

  always_comb begin
    strobes.forceMin = ~|voteMask;
    strobes.capEff   = allAsleep;
  end

  always_comb begin
    if (!allAsleep)   nextState = PKG_ACTIVE;
    else if (!allDeep) nextState = PKG_LIGHT;
    else if (!ioQuiet) nextState = PKG_HOLD;
    else               nextState = PKG_DEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= PKG_ACTIVE;
      uncoreQ <= 1'b1;
    end else begin
      stateQ  <= nextState;
      uncoreQ <= (nextState != PKG_DEEP);
    end
  end

  assign pkgState     = stateQ;
  assign uncoreActive = uncoreQ;

  // any core in C0 keeps the package active
  assert_active_pkg_R7: assert property (@(posedge clk) disable iff (rst)
    !allAsleep |=> pkgState == PKG_ACTIVE);

  // quiet traffic and deep cores release the uncore
  assert_deep_release_R8: assert property (@(posedge clk) disable iff (rst)
    (allDeep && ioQuiet) |=> (pkgState == PKG_DEEP) && !uncoreActive);

  // live traffic holds the uncore up
  assert_uncore_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (allDeep && !ioQuiet) |=> (pkgState == PKG_HOLD) && uncoreActive);

endmodule

// File: rtl/arb_ratio_path.sv
module arb_ratio_path
  import pkg_arb_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int RATIO_W   = 8,
  parameter int MIN_RATIO = 8,
  parameter int EFF_RATIO = 16,
  parameter int MAX_RATIO = 40
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CORES*RATIO_W-1:0] coreRatioReq,
  input  logic [NUM_CORES-1:0]         voteMask,
  input  arbStrobes_t                  strobes,
  output logic [RATIO_W-1:0]           grantRatio
);

  localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] EFF_R = RATIO_W'(EFF_RATIO);
  localparam logic [RATIO_W-1:0] MAX_R = RATIO_W'(MAX_RATIO);

  logic [RATIO_W-1:0] clampedReq [NUM_CORES];
  logic [RATIO_W-1:0] voteMax;
  logic [RATIO_W-1:0] nextRatio;
  logic [RATIO_W-1:0] ratioQ;

  generate
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_clamp
      logic [RATIO_W-1:0] rawReq;
      assign rawReq = coreRatioReq[g*RATIO_W +: RATIO_W];
      assign clampedReq[g] = (rawReq < MIN_R) ? MIN_R :
                             (rawReq > MAX_R) ? MAX_R : rawReq;
    end
  endgenerate

  always_comb begin
    voteMax = MIN_R;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (voteMask[i] && (clampedReq[i] > voteMax)) voteMax = clampedReq[i];
    end
  end

  always_comb begin
    if (strobes.forceMin)                        nextRatio = MIN_R;
    else if (strobes.capEff && (voteMax > EFF_R)) nextRatio = EFF_R;
    else                                          nextRatio = voteMax;
  end

  always_ff @(posedge clk) begin
    if (rst) ratioQ <= MIN_R;
    else     ratioQ <= nextRatio;
  end

  assign grantRatio = ratioQ;

  // granted ratio never leaves the supported window
  assert_ratio_range_R2: assert property (@(posedge clk) disable iff (rst)
    (grantRatio >= MIN_R) && (grantRatio <= MAX_R));

  // no voter means floor ratio next cycle
  assert_no_vote_min_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.forceMin |=> grantRatio == MIN_R);

  // package-wide sleep caps the ratio
  assert_eff_cap_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.capEff |=> grantRatio <= EFF_R);

endmodule

// File: rtl/pkg_freq_idle_arb.sv
module pkg_freq_idle_arb
  import pkg_arb_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int RATIO_W   = 8,
  parameter int MIN_RATIO = 8,
  parameter int EFF_RATIO = 16,
  parameter int MAX_RATIO = 40
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CORES*3-1:0]       coreCState,
  input  logic [NUM_CORES*RATIO_W-1:0] coreRatioReq,
  input  logic                         pcieIdle,
  input  logic                         remoteIdle,
  output logic [RATIO_W-1:0]           grantRatio,
  output logic [1:0]                   pkgState,
  output logic                         uncoreActive
);

  logic [NUM_CORES-1:0] voteMask;
  arbStrobes_t          strobes;

  arb_ctrl #(
    .NUM_CORES(NUM_CORES)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .coreCState  (coreCState),
    .pcieIdle    (pcieIdle),
    .remoteIdle  (remoteIdle),
    .voteMask    (voteMask),
    .strobes     (strobes),
    .pkgState    (pkgState),
    .uncoreActive(uncoreActive)
  );

  arb_ratio_path #(
    .NUM_CORES(NUM_CORES),
    .RATIO_W  (RATIO_W),
    .MIN_RATIO(MIN_RATIO),
    .EFF_RATIO(EFF_RATIO),
    .MAX_RATIO(MAX_RATIO)
  ) u_path (
    .clk         (clk),
    .rst         (rst),
    .coreRatioReq(coreRatioReq),
    .voteMask    (voteMask),
    .strobes     (strobes),
    .grantRatio  (grantRatio)
  );

endmodule

// File: tb/pkg_freq_idle_arb_test.sv
module pkg_freq_idle_arb_test;

  localparam int NC   = 4;
  localparam int RW   = 8;
  localparam int MINR = 8;
  localparam int EFFR = 16;
  localparam int MAXR = 40;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NC*3-1:0] coreCState = '0;
  logic [NC*RW-1:0] coreRatioReq = '0;
  logic            pcieIdle = 1'b1;
  logic            remoteIdle = 1'b1;
  logic [RW-1:0]   grantRatio;
  logic [1:0]      pkgState;
  logic            uncoreActive;

  int testCount = 0;
  int failCount = 0;

  int cs [NC];
  int rq [NC];

  always #5 clk = ~clk;

  pkg_freq_idle_arb #(
    .NUM_CORES(NC), .RATIO_W(RW), .MIN_RATIO(MINR),
    .EFF_RATIO(EFFR), .MAX_RATIO(MAXR)
  ) uut (
    .clk(clk), .rst(rst), .coreCState(coreCState), .coreRatioReq(coreRatioReq),
    .pcieIdle(pcieIdle), .remoteIdle(remoteIdle),
    .grantRatio(grantRatio), .pkgState(pkgState), .uncoreActive(uncoreActive)
  );

  // bench model of the state codes
  function automatic int normCode(input int c);
    if (c == 1 || c == 2 || c == 3 || c == 6) return c;
    return 0;
  endfunction

  function automatic int expRatio();
    int best = -1;
    bit allOut = 1'b1;
    for (int i = 0; i < NC; i++) begin
      int c = normCode(cs[i]);
      int r = rq[i] < MINR ? MINR : (rq[i] > MAXR ? MAXR : rq[i]);
      if (c == 0) allOut = 1'b0;
      if ((c == 0 || c == 1) && r > best) best = r;
    end
    if (best < 0) return MINR;
    if (allOut && best > EFFR) return EFFR;
    return best;
  endfunction

  function automatic int expState();
    bit allOut = 1'b1;
    bit allDeep = 1'b1;
    for (int i = 0; i < NC; i++) begin
      int c = normCode(cs[i]);
      if (c == 0) allOut = 1'b0;
      if (!(c == 3 || c == 6)) allDeep = 1'b0;
    end
    if (!allOut) return 0;
    if (!allDeep) return 1;
    if (!(pcieIdle && remoteIdle)) return 2;
    return 3;
  endfunction

  task automatic drive();
    for (int i = 0; i < NC; i++) begin
      coreCState[i*3 +: 3]    = 3'(cs[i]);
      coreRatioReq[i*RW +: RW] = RW'(rq[i]);
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    int es = expState();
    check({tag, " ratio"}, int'(grantRatio), expRatio());
    check({tag, " state"}, int'(pkgState), es);
    check({tag, " uncore"}, int'(uncoreActive), (es == 3) ? 0 : 1);
  endtask

  task automatic setCase(input int c0, c1, c2, c3, r0, r1, r2, r3);
    cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3;
    rq[0] = r0; rq[1] = r1; rq[2] = r2; rq[3] = r3;
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic step(input string tag);
    @(negedge clk);
    drive();
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    #2_000_000;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    int codes [8] = '{0, 1, 2, 3, 6, 4, 5, 7};
    void'($urandom(32'd20240611));
    setCase(6, 6, 6, 6, 60, 60, 60, 60);
    drive();
    repeat (3) @(negedge clk);
    // R10: reset state even with deep-sleep inputs
    check("R10 ratio", int'(grantRatio), MINR);
    check("R10 state", int'(pkgState), 0);
    check("R10 uncore", int'(uncoreActive), 1);
    rst = 1'b0;

    setCase(0, 0, 0, 0, 5, 20, 50, 30);   step("R1 R2 all run clamp high");
    setCase(0, 0, 0, 0, 2, 3, 0, 1);      step("R2 all low clamp");
    setCase(0, 6, 3, 2, 9, 60, 60, 60);   step("R3 sleepers lose vote");
    setCase(1, 1, 3, 6, 30, 25, 60, 60);  step("R5 R7 light cap");
    setCase(1, 3, 6, 3, 11, 60, 60, 60);  step("R5 below cap");
    setCase(2, 3, 6, 2, 30, 30, 30, 30);  step("R4 no voter");
    pcieIdle = 1'b1; remoteIdle = 1'b1;
    setCase(3, 6, 3, 6, 30, 30, 30, 30);  step("R8 deep");
    pcieIdle = 1'b0;                       step("R9 pcie busy");
    pcieIdle = 1'b1; remoteIdle = 1'b0;    step("R9 remote busy");
    remoteIdle = 1'b1;
    setCase(4, 5, 7, 7, 10, 22, 12, 3);   step("R6 unknown codes");
    setCase(7, 6, 6, 6, 33, 60, 60, 60);  step("R6 unknown votes");

    // R11: outputs hold until the next rising edge
    setCase(0, 0, 0, 0, 20, 20, 20, 20);  step("R11 base");
    @(negedge clk);
    setCase(3, 3, 3, 3, 30, 30, 30, 30);
    drive();
    #1;
    check("R11 hold ratio", int'(grantRatio), 20);
    check("R11 hold state", int'(pkgState), 0);
    @(negedge clk);
    checkAll("R11 update");

    // random mixes
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < NC; i++) begin
        cs[i] = ($urandom % 3 == 0) ? codes[$urandom % 8] : (($urandom % 2) ? 3 : 6);
        rq[i] = $urandom % 64;
      end
      pcieIdle   = ($urandom % 4) != 0;
      remoteIdle = ($urandom % 4) != 0;
      step("R1 R7 random");
    end

    // R10: reset in mid-run
    setCase(0, 0, 0, 0, 35, 35, 35, 35);  step("R1 pre-reset");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid ratio", int'(grantRatio), MINR);
    check("R10 mid state", int'(pkgState), 0);
    rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule